// File: doc/BRIEF.md
# Bus Initiator Latency Timer

This block sits beside the initiator state machine of a shared-bus master and decides when a long burst has to give up the bus. Software programs a 16-bit configuration word: the upper byte is the latency limit in bus clock cycles and the lower byte is the system cache line size. When the master drives FRAME to start a transaction, a cycle counter begins at zero. Once the count has reached the limit, the transaction is marked expired. It is actually cut short only when the arbiter has also withdrawn the grant.

The same word also steers command selection. While a burst still has at least one whole cache line to move and the line size is nonzero, the block tells the master that the line-oriented memory commands (write-and-invalidate, read-line, read-multiple) may be used. Configuration writes carry byte enables, so each byte can be updated on its own. A write that lands in the middle of a transaction changes the readback value at once, but the running transaction keeps the values it started with.

Top module: `lat_guard`

## Requirements
- R1: After reset the configuration readback is 0000h, and `expired_o`, `end_req_o` and `line_cmd_ok_o` are low.
- R2: A write with `cfg_wr_be[0]` set loads bits 7:0 (line size) and one with `cfg_wr_be[1]` set loads bits 15:8 (latency limit). A cleared enable leaves its byte unchanged. The new value appears on `cfg_rd_data` in the cycle after the write edge.
- R3: The cycle in which `frame_i` first goes high has count 0, and each later cycle with `frame_i` high adds one. `expired_o` is high in every cycle of the transaction whose count is greater than or equal to the latency limit.
- R4: `expired_o` stays high until `frame_i` goes low, and it is low in every cycle where `frame_i` is low.
- R5: `end_req_o` is high exactly when `expired_o` is high and `gnt_i` is low. A held grant lets the burst continue past expiry, and the request rises in the first cycle the grant is low.
- R6: A latency limit of 0 makes `expired_o` high already in the first cycle of a transaction.
- R7: The count saturates at 255 and does not wrap, so a transaction with limit 255 stays expired for as long as it lasts.
- R8: `line_cmd_ok_o` is high only when the line size is nonzero and `rem_len_i` (remaining length, same units as the line size) is at least the line size.
- R9: A configuration write during a transaction does not change that transaction's latency limit or line size. The written values take effect from the next transaction.
- R10: Dropping `frame_i` clears the count, so the next transaction counts from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_be | input | 2 | Byte enables for the configuration write |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Current configuration word |
| frame_i | input | 1 | High while this master drives FRAME as initiator |
| gnt_i | input | 1 | High while the arbiter grants the bus to this master |
| rem_len_i | input | 12 | Remaining transfer length of the current burst |
| expired_o | output | 1 | Latency limit reached in the current transaction |
| end_req_o | output | 1 | Request to the master to end the transaction |
| line_cmd_ok_o | output | 1 | Line-oriented memory commands permitted |

## Verification
The status outputs depend combinationally on the current `frame_i`, `gnt_i` and `rem_len_i` and on registered state, so each result is due in the same cycle as the stimulus that produced it. Configuration readback is due one edge after the write. The driver applies each cycle's inputs at the falling edge and pushes the expected outputs for that cycle into a queue. The monitor pops that entry one nanosecond later, still before the next rising edge. Because the expected count advances only at rising edges where `frame_i` was sampled high, the expiry cycle (count equal to the limit) is checked exactly, together with the cycle just before it.

// File: rtl/lt_pkg.sv
package lt_pkg;
   localparam int BYTE_W  = 8;
   localparam int CFG_W   = 16;
   localparam int CFG_BYT = CFG_W / BYTE_W;

   typedef struct packed {
      logic [BYTE_W-1:0] lat;
      logic [BYTE_W-1:0] line;
   } lt_cfg_t;
endpackage

// File: rtl/lt_cfg_reg.sv
module lt_cfg_reg #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [LANES-1:0]         wr_be,
   input  logic [LANES*LANE_W-1:0]  wr_data,
   output logic [LANES*LANE_W-1:0]  q
);
   if (LANES < 1 || LANE_W < 1) begin : g_bad_geom
      $error("lt_cfg_reg: lane geometry must be positive");
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q[b*LANE_W +: LANE_W] <= '0;
         end else if (wr_en && wr_be[b]) begin
            q[b*LANE_W +: LANE_W] <= wr_data[b*LANE_W +: LANE_W];
         end
      end
   end
endmodule

// File: rtl/lt_sat_counter.sv
module lt_sat_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1) begin : g_bad_w
      $error("lt_sat_counter: CNT_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (!run) begin
         count <= '0;
      end else if (count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end
endmodule

// File: rtl/lt_expiry.sv
module lt_expiry #(
   parameter int CNT_W = 8,
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame,
   input  logic             gnt,
   input  logic [CNT_W-1:0] count,
   input  logic [LAT_W-1:0] limit,
   output logic             expired,
   output logic             end_req
);
   localparam int CMP_W = (CNT_W > LAT_W) ? CNT_W : LAT_W;

   logic [CMP_W-1:0] cnt_x;
   logic [CMP_W-1:0] lim_x;
   logic             reached;
   logic             sticky_q;

   if (CNT_W < LAT_W) begin : g_bad_w
      $error("lt_expiry: counter narrower than limit can never reach it");
   end

   if (CNT_W == CMP_W) begin : g_cnt_wide
      assign cnt_x = count;
   end else begin : g_cnt_ext
      assign cnt_x = {{(CMP_W-CNT_W){1'b0}}, count};
   end

   if (LAT_W == CMP_W) begin : g_lim_wide
      assign lim_x = limit;
   end else begin : g_lim_ext
      assign lim_x = {{(CMP_W-LAT_W){1'b0}}, limit};
   end

   assign reached = (cnt_x >= lim_x);
   assign expired = frame && (sticky_q || reached);
   assign end_req = expired && !gnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
      end else begin
         sticky_q <= expired;
      end
   end
endmodule

// File: rtl/lt_line_gate.sv
module lt_line_gate #(
   parameter int LINE_W = 8,
   parameter int LEN_W  = 12
) (
   input  logic [LINE_W-1:0] line,
   input  logic [LEN_W-1:0]  rem_len,
   output logic              ok
);
   localparam int CMP_W = (LEN_W > LINE_W) ? LEN_W : LINE_W;

   logic [CMP_W-1:0] line_x;
   logic [CMP_W-1:0] len_x;

   if (LINE_W == CMP_W) begin : g_line_wide
      assign line_x = line;
   end else begin : g_line_ext
      assign line_x = {{(CMP_W-LINE_W){1'b0}}, line};
   end

   if (LEN_W == CMP_W) begin : g_len_wide
      assign len_x = rem_len;
   end else begin : g_len_ext
      assign len_x = {{(CMP_W-LEN_W){1'b0}}, rem_len};
   end

   assign ok = (line != '0) && (len_x >= line_x);
endmodule

// File: rtl/lat_guard.sv
module lat_guard #(
   parameter int CNT_W = 8,
   parameter int LEN_W = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr_en,
   input  logic [lt_pkg::CFG_BYT-1:0] cfg_wr_be,
   input  logic [lt_pkg::CFG_W-1:0]   cfg_wr_data,
   output logic [lt_pkg::CFG_W-1:0]   cfg_rd_data,
   input  logic                       frame_i,
   input  logic                       gnt_i,
   input  logic [LEN_W-1:0]           rem_len_i,
   output logic                       expired_o,
   output logic                       end_req_o,
   output logic                       line_cmd_ok_o
);
   import lt_pkg::*;

   localparam int LAT_W  = BYTE_W;
   localparam int LINE_W = BYTE_W;

   if (LEN_W < 1) begin : g_bad_len
      $error("lat_guard: LEN_W must be positive");
   end

   lt_cfg_t           cfg_q;
   lt_cfg_t           snap_q;
   lt_cfg_t           eff;
   logic              active_q;
   logic              in_txn;
   logic [CNT_W-1:0]  count;
   logic [CFG_W-1:0]  cfg_bits;

   lt_cfg_reg #(.LANES(CFG_BYT), .LANE_W(BYTE_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_be   (cfg_wr_be),
      .wr_data (cfg_wr_data),
      .q       (cfg_bits)
   );

   assign cfg_q       = lt_cfg_t'(cfg_bits);
   assign cfg_rd_data = cfg_bits;

   // A transaction is "running" once FRAME has been seen at an edge; in its
   // first cycle the live register still supplies the values.
   assign in_txn = frame_i && active_q;
   assign eff    = in_txn ? snap_q : cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         snap_q   <= '0;
      end else begin
         active_q <= frame_i;
         if (frame_i && !active_q) begin
            snap_q <= cfg_q;
         end
      end
   end

   lt_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (frame_i),
      .count (count)
   );

   lt_expiry #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_exp (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame   (frame_i),
      .gnt     (gnt_i),
      .count   (count),
      .limit   (eff.lat),
      .expired (expired_o),
      .end_req (end_req_o)
   );

   lt_line_gate #(.LINE_W(LINE_W), .LEN_W(LEN_W)) u_line (
      .line    (eff.line),
      .rem_len (rem_len_i),
      .ok      (line_cmd_ok_o)
   );
endmodule

// File: rtl/lat_guard_chk.sv
module lat_guard_chk #(
   parameter int LEN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr_en,
   input logic [1:0]       cfg_wr_be,
   input logic [15:0]      cfg_wr_data,
   input logic [15:0]      cfg_rd_data,
   input logic             frame_i,
   input logic             gnt_i,
   input logic [LEN_W-1:0] rem_len_i,
   input logic             expired_o,
   input logic             end_req_o,
   input logic             line_cmd_ok_o
);
   assert_low_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_be[0]) |=> cfg_rd_data[7:0] == $past(cfg_wr_data[7:0]));

   assert_high_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_be[1]) |=> cfg_rd_data[15:8] == $past(cfg_wr_data[15:8]));

   assert_no_write_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_en |=> $stable(cfg_rd_data));

   assert_expiry_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && frame_i) |=> (!frame_i || expired_o));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_i |-> (!expired_o && !end_req_o));

   assert_grant_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_i |-> !end_req_o);

   assert_zero_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_i && !$past(frame_i) && cfg_rd_data[15:8] == 8'h00) |-> expired_o);

   assert_line_needs_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_cmd_ok_o |-> (rem_len_i != '0));
endmodule

bind lat_guard lat_guard_chk #(.LEN_W(LEN_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_wr_en     (cfg_wr_en),
   .cfg_wr_be     (cfg_wr_be),
   .cfg_wr_data   (cfg_wr_data),
   .cfg_rd_data   (cfg_rd_data),
   .frame_i       (frame_i),
   .gnt_i         (gnt_i),
   .rem_len_i     (rem_len_i),
   .expired_o     (expired_o),
   .end_req_o     (end_req_o),
   .line_cmd_ok_o (line_cmd_ok_o)
);

// File: tb/tb_lat_guard.sv
module tb_lat_guard;
   localparam real CLK_NS = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [1:0]  cfg_wr_be = 2'b00;
   logic [15:0] cfg_wr_data = '0;
   logic [15:0] cfg_rd_data;
   logic        frame_i = 1'b0;
   logic        gnt_i = 1'b1;
   logic [11:0] rem_len_i = '0;
   logic        expired_o;
   logic        end_req_o;
   logic        line_cmd_ok_o;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   logic [18:0] q_exp[$];
   string       q_tag[$];

   // bench model state
   logic [15:0] m_cfg = '0;
   logic [7:0]  m_lat = '0;
   logic [7:0]  m_line = '0;
   logic [7:0]  m_cnt = '0;
   logic        m_act = 1'b0;
   logic        m_exp = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   lat_guard dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr_en     (cfg_wr_en),
      .cfg_wr_be     (cfg_wr_be),
      .cfg_wr_data   (cfg_wr_data),
      .cfg_rd_data   (cfg_rd_data),
      .frame_i       (frame_i),
      .gnt_i         (gnt_i),
      .rem_len_i     (rem_len_i),
      .expired_o     (expired_o),
      .end_req_o     (end_req_o),
      .line_cmd_ok_o (line_cmd_ok_o)
   );

   task automatic check1(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // driver: one bus cycle, expected outputs pushed to the scoreboard
   task automatic cyc(input logic f, input logic g, input logic [11:0] r,
                      input logic we, input logic [1:0] be, input logic [15:0] wd,
                      input string tag);
      logic       start;
      logic [7:0] lat;
      logic [7:0] line;
      logic       e_exp;
      logic       e_end;
      logic       e_line;
      @(negedge clk);
      frame_i = f; gnt_i = g; rem_len_i = r;
      cfg_wr_en = we; cfg_wr_be = be; cfg_wr_data = wd;
      start  = f && !m_act;
      lat    = (f && m_act) ? m_lat  : m_cfg[15:8];
      line   = (f && m_act) ? m_line : m_cfg[7:0];
      e_exp  = f && (m_exp || (m_cnt >= lat));
      e_end  = e_exp && !g;
      e_line = (line != 8'd0) && ({4'd0, line} <= r);
      q_exp.push_back({m_cfg, e_exp, e_end, e_line});
      q_tag.push_back(tag);
      // model advance at the coming rising edge
      if (start) begin
         m_lat  = m_cfg[15:8];
         m_line = m_cfg[7:0];
      end
      if (we && be[0]) m_cfg[7:0]  = wd[7:0];
      if (we && be[1]) m_cfg[15:8] = wd[15:8];
      m_act = f;
      m_exp = e_exp;
      if (!f) m_cnt = 8'd0;
      else if (m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
   endtask

   task automatic bus(input logic f, input logic g, input logic [11:0] r, input string tag);
      cyc(f, g, r, 1'b0, 2'b00, 16'h0000, tag);
   endtask

   task automatic wr(input logic [1:0] be, input logic [15:0] wd, input string tag);
      cyc(1'b0, 1'b1, 12'd0, 1'b1, be, wd, tag);
   endtask

   // monitor: compares each cycle's outputs before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q_exp.size() > 0) begin
            logic [18:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check1(t, "cfg_rd_data",   cfg_rd_data,            e[18:3]);
            check1(t, "expired_o",     {15'd0, expired_o},     {15'd0, e[2]});
            check1(t, "end_req_o",     {15'd0, end_req_o},     {15'd0, e[1]});
            check1(t, "line_cmd_ok_o", {15'd0, line_cmd_ok_o}, {15'd0, e[0]});
         end
      end
   end

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      bus(1'b0, 1'b1, 12'd40, "R1");
      bus(1'b0, 1'b1, 12'd40, "R1");

      // R2: byte-enable writes
      wr(2'b01, 16'hAB12, "R2");
      bus(1'b0, 1'b1, 12'd0, "R2");
      wr(2'b10, 16'h34FF, "R2");
      bus(1'b0, 1'b1, 12'd0, "R2");
      wr(2'b00, 16'hFFFF, "R2");
      bus(1'b0, 1'b1, 12'd0, "R2");

      // limit 4, line 8
      wr(2'b11, 16'h0408, "R2");
      bus(1'b0, 1'b1, 12'd8, "R8");
      // R3/R5: grant held past expiry, then withdrawn
      for (int i = 0; i < 8; i++) bus(1'b1, 1'b1, 12'd16, "R3");
      bus(1'b1, 1'b0, 12'd16, "R5");
      bus(1'b1, 1'b0, 12'd16, "R5");
      // R4: cleared when frame drops
      bus(1'b0, 1'b1, 12'd16, "R4");
      // R10: new transaction counts from zero, grant lost early
      for (int i = 0; i < 6; i++) bus(1'b1, 1'b0, 12'd16, "R10");
      bus(1'b0, 1'b0, 12'd16, "R10");

      // R8: line command gate
      bus(1'b0, 1'b1, 12'd7,  "R8");
      bus(1'b0, 1'b1, 12'd8,  "R8");
      bus(1'b0, 1'b1, 12'd300, "R8");
      wr(2'b01, 16'h0000, "R8");
      bus(1'b0, 1'b1, 12'd300, "R8");

      // R6: zero limit expires at once
      wr(2'b10, 16'h0000, "R6");
      bus(1'b1, 1'b1, 12'd0, "R6");
      bus(1'b1, 1'b0, 12'd0, "R6");
      bus(1'b0, 1'b1, 12'd0, "R6");

      // R9: write during transaction affects only the next one
      wr(2'b11, 16'h0604, "R9");
      bus(1'b1, 1'b0, 12'd4, "R9");
      cyc(1'b1, 1'b0, 12'd4, 1'b1, 2'b11, 16'h0110, "R9");
      for (int i = 0; i < 6; i++) bus(1'b1, 1'b0, 12'd4, "R9");
      bus(1'b0, 1'b1, 12'd4, "R9");
      for (int i = 0; i < 3; i++) bus(1'b1, 1'b0, 12'd16, "R9");
      bus(1'b0, 1'b1, 12'd4, "R9");

      // R7: saturation with limit 255
      wr(2'b10, 16'hFF00, "R7");
      for (int i = 0; i < 300; i++) bus(1'b1, (i < 250), 12'd0, "R7");
      bus(1'b0, 1'b1, 12'd0, "R7");
      bus(1'b0, 1'b1, 12'd0, "R7");

      while (q_exp.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule